// File: doc/BRIEF.md
# Triggered SPI Command Program Replayer

This block holds a short SPI command program and the static transmit words that go with it in two small local memories. Once the host has loaded both memories and set the enable bit, each pulse on the external trigger input replays the whole stored program toward a downstream command execution engine. The commands are issued from the first entry to the last one loaded, and the transmit words are offered on a separate stream in load order. Neither memory is consumed, so the next trigger replays exactly the same transaction without any processor action.

A replay finishes when the engine reports that it has executed the program's closing sync instruction, which carries ID 0. The block then raises a one-cycle completion pulse and returns to idle. A small register port appends entries to the memories, sets the enable and clear controls, shows busy and overflow status, and reports the memory depths so that software can check that a program fits.

Top module: `trig_prog_seq`

## Requirements
- R1: A write to register address 4 appends `reg_wdata[15:0]` to the command memory at the next free entry. Replays issue the entries in the order they were written.
- R2: A write to register address 5 appends `reg_wdata[SDO_W-1:0]` to the transmit memory at the next free entry. Replays offer the entries in the order they were written.
- R3: When a trigger pulse is sampled while the block is idle and enabled, the block enters the run state on the next edge. `cmd_valid` stays high and presents entries 0 to the last loaded one, each held until it is accepted with `cmd_ready`, and it drops after the last entry is accepted.
- R4: During a replay, `sdo_valid` offers transmit entries starting again from entry 0 on each trigger, each held until `sdo_ready` is high. It goes low once every loaded entry has been accepted. With an empty transmit memory it is never raised.
- R5: While bit 0 of control register address 0 is clear, a trigger pulse does not start a replay.
- R6: A trigger pulse that arrives while a replay is in progress is ignored and does not restart the program.
- R7: A replay leaves both memories unchanged, so a later trigger issues the same commands and words again.
- R8: After the last command has been accepted, a `sync_valid` cycle with `sync_id` = 0 raises `offload_done` for exactly one cycle on the next edge and returns the block to idle. A sync with any other ID is ignored.
- R9: While bit 0 of register address 1 is set, both memories are emptied, any replay is abandoned, the overflow flag is cleared and appends are dropped. Clearing the bit allows a new program to be loaded.
- R10: Register address 3 reads log2 of the command memory depth in bits [7:0] and log2 of the transmit memory depth in bits [15:8]. This is 0x0404 for the default depths of 16.
- R11: An append to a full memory is dropped without changing the stored entries, and it sets the sticky overflow flag, which is read at bit 1 of register address 2.
- R12: Bit 0 of register address 2 reads 1 from the edge that starts a replay until the edge that completes or abandons it. Register addresses 0 and 1 read back their stored bit 0.
- R13: A trigger pulse while the command memory is empty does not start a replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for writes and for the read data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| trigger | input | 1 | Replay request pulse |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Engine accepts the command word |
| cmd_data | output | 16 | Command word |
| sdo_valid | output | 1 | Transmit word available |
| sdo_ready | input | 1 | Engine accepts the transmit word |
| sdo_data | output | SDO_W | Transmit word |
| sync_valid | input | 1 | Engine executed a sync instruction |
| sync_id | input | ID_W | ID carried by that sync instruction |
| offload_done | output | 1 | One-cycle completion pulse |

## Verification
A command pointer that slips, wraps or restarts shows on `cmd_data` in the same cycle that `cmd_valid` is compared. The captured order of accepted words exposes it at the end of a replay. A transmit pointer that is not rewound on a new trigger shows on the second replay as a missing or shifted first word. A wrong run state shows up as a busy bit, a `cmd_valid`, or a completion pulse that differs from the reference model in the very cycle it diverges. A lost entry count shows on the overflow bit and on the length of the next replay.

// File: rtl/tps_pkg.sv
package tps_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_WAIT = 2'd2
    } sq_state_e;

    localparam logic [2:0] RA_CTRL     = 3'd0;
    localparam logic [2:0] RA_CLEAR    = 3'd1;
    localparam logic [2:0] RA_STATUS   = 3'd2;
    localparam logic [2:0] RA_SIZE     = 3'd3;
    localparam logic [2:0] RA_CMD_PUSH = 3'd4;
    localparam logic [2:0] RA_SDO_PUSH = 3'd5;

    localparam int CMD_W = 16;
endpackage

// File: rtl/prog_store.sv
module prog_store #(
    parameter int W  = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic [W-1:0]  push_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [W-1:0]  rd_data_o,
    output logic [AW:0]   count_o,
    output logic          drop_o
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic full, take;

    // count never exceeds DEPTH, so the top bit alone marks a full store
    assign full   = st_q.cnt[AW];
    assign take   = push_i && !clear_i && !full;
    assign drop_o = push_i && !clear_i && full;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (take) begin
            st_d.cnt = st_q.cnt + (AW+1)'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            mem[st_q.cnt[AW-1:0]] <= push_data_i;
        end
    end

    assign rd_data_o = mem[rd_addr_i];
    assign count_o   = st_q.cnt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt <= (AW+1)'(DEPTH))) else $error("count beyond depth"); // R11
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.cnt == '0)) else $error("clear left entries"); // R9
    AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> $stable(st_q.cnt)) else $error("dropped write stored"); // R11
endmodule

// File: rtl/replay_seq.sv
module replay_seq
    import tps_pkg::*;
#(
    parameter int CMD_AW = 4,
    parameter int SDO_AW = 4,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              enable_i,
    input  logic              trigger_i,
    input  logic [CMD_AW:0]   cmd_cnt_i,
    input  logic [SDO_AW:0]   sdo_cnt_i,
    input  logic              cmd_ready_i,
    input  logic              sdo_ready_i,
    input  logic              sync_valid_i,
    input  logic [ID_W-1:0]   sync_id_i,
    output logic [CMD_AW-1:0] cmd_addr_o,
    output logic [SDO_AW-1:0] sdo_addr_o,
    output logic              cmd_valid_o,
    output logic              sdo_valid_o,
    output logic              busy_o,
    output logic              done_o
);
    typedef struct packed {
        sq_state_e         state;
        logic [CMD_AW-1:0] cptr;
        logic [SDO_AW:0]   sptr;
        logic              done;
    } seq_t;

    seq_t sq_d, sq_q;
    logic last_cmd, sdo_go;

    assign last_cmd = ({1'b0, sq_q.cptr} == (cmd_cnt_i - (CMD_AW+1)'(1)));
    assign sdo_go   = sdo_valid_o && sdo_ready_i;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        if (abort_i) begin
            sq_d.state = SQ_IDLE;
            sq_d.cptr  = '0;
            sq_d.sptr  = '0;
        end else begin
            case (sq_q.state)
                SQ_IDLE: begin
                    if (enable_i && trigger_i && (cmd_cnt_i != '0)) begin
                        sq_d.state = SQ_RUN;
                        sq_d.cptr  = '0;
                        sq_d.sptr  = '0;
                    end
                end
                SQ_RUN: begin
                    if (cmd_ready_i) begin
                        if (last_cmd) begin
                            sq_d.state = SQ_WAIT;
                        end else begin
                            sq_d.cptr = sq_q.cptr + CMD_AW'(1);
                        end
                    end
                end
                SQ_WAIT: begin
                    if (sync_valid_i && (sync_id_i == '0)) begin
                        sq_d.state = SQ_IDLE;
                        sq_d.done  = 1'b1;
                    end
                end
                default: sq_d.state = SQ_IDLE;
            endcase
            if (sdo_go) begin
                sq_d.sptr = sq_q.sptr + (SDO_AW+1)'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{state: SQ_IDLE, cptr: '0, sptr: '0, done: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign cmd_valid_o = (sq_q.state == SQ_RUN);
    assign sdo_valid_o = (sq_q.state != SQ_IDLE) && (sq_q.sptr < sdo_cnt_i);
    assign busy_o      = (sq_q.state != SQ_IDLE);
    assign done_o      = sq_q.done;
    assign cmd_addr_o  = sq_q.cptr;
    assign sdo_addr_o  = sq_q.sptr[SDO_AW-1:0];

    AST_CMD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> ({1'b0, sq_q.cptr} < cmd_cnt_i)) else $error("cmd pointer past program"); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i && !abort_i) |=> $stable(sq_q.cptr)) else $error("pointer moved without accept"); // R6
    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !busy_o) |=> !busy_o) else $error("started while disabled"); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("completion pulse too long"); // R8
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !busy_o) else $error("clear did not stop replay"); // R9
endmodule

// File: rtl/trig_prog_seq.sv
module trig_prog_seq
    import tps_pkg::*;
#(
    parameter int CMD_AW = 4,
    parameter int SDO_AW = 4,
    parameter int SDO_W  = 32,
    parameter int ID_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             trigger,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [15:0]      cmd_data,
    output logic             sdo_valid,
    input  logic             sdo_ready,
    output logic [SDO_W-1:0] sdo_data,
    input  logic             sync_valid,
    input  logic [ID_W-1:0]  sync_id,
    output logic             offload_done
);
    localparam logic [31:0] SIZE_WORD = {16'h0, 8'(SDO_AW), 8'(CMD_AW)};

    typedef struct packed {
        logic en;
        logic hold;
        logic ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              cmd_push, sdo_push, cmd_drop, sdo_drop, busy;
    logic [CMD_AW:0]   cmd_cnt;
    logic [SDO_AW:0]   sdo_cnt;
    logic [CMD_AW-1:0] cmd_addr;
    logic [SDO_AW-1:0] sdo_addr;

    assign cmd_push = reg_wr && (reg_addr == RA_CMD_PUSH) && !ctl_q.hold;
    assign sdo_push = reg_wr && (reg_addr == RA_SDO_PUSH) && !ctl_q.hold;

    prog_store #(.W(CMD_W), .AW(CMD_AW)) u_cmd_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (ctl_q.hold),
        .push_i      (cmd_push),
        .push_data_i (reg_wdata[CMD_W-1:0]),
        .rd_addr_i   (cmd_addr),
        .rd_data_o   (cmd_data),
        .count_o     (cmd_cnt),
        .drop_o      (cmd_drop)
    );

    prog_store #(.W(SDO_W), .AW(SDO_AW)) u_sdo_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (ctl_q.hold),
        .push_i      (sdo_push),
        .push_data_i (reg_wdata[SDO_W-1:0]),
        .rd_addr_i   (sdo_addr),
        .rd_data_o   (sdo_data),
        .count_o     (sdo_cnt),
        .drop_o      (sdo_drop)
    );

    replay_seq #(.CMD_AW(CMD_AW), .SDO_AW(SDO_AW), .ID_W(ID_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort_i      (ctl_q.hold),
        .enable_i     (ctl_q.en),
        .trigger_i    (trigger),
        .cmd_cnt_i    (cmd_cnt),
        .sdo_cnt_i    (sdo_cnt),
        .cmd_ready_i  (cmd_ready),
        .sdo_ready_i  (sdo_ready),
        .sync_valid_i (sync_valid),
        .sync_id_i    (sync_id),
        .cmd_addr_o   (cmd_addr),
        .sdo_addr_o   (sdo_addr),
        .cmd_valid_o  (cmd_valid),
        .sdo_valid_o  (sdo_valid),
        .busy_o       (busy),
        .done_o       (offload_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && (reg_addr == RA_CTRL)) begin
            ctl_d.en = reg_wdata[0];
        end
        if (reg_wr && (reg_addr == RA_CLEAR)) begin
            ctl_d.hold = reg_wdata[0];
        end
        if (ctl_q.hold) begin
            ctl_d.ovf = 1'b0;
        end else if (cmd_drop || sdo_drop) begin
            ctl_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:   reg_rdata = {31'h0, ctl_q.en};
            RA_CLEAR:  reg_rdata = {31'h0, ctl_q.hold};
            RA_STATUS: reg_rdata = {30'h0, ctl_q.ovf, busy};
            RA_SIZE:   reg_rdata = SIZE_WORD;
            default:   reg_rdata = 32'h0;
        endcase
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ovf && !ctl_q.hold) |=> ctl_q.ovf) else $error("overflow flag lost"); // R11
    AST_HOLD_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.hold && !busy) |=> !busy) else $error("replay started under clear"); // R9
endmodule

// File: tb/trig_prog_seq_bench.sv
module trig_prog_seq_bench;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        trigger = 1'b0;
    logic        cmd_valid, cmd_ready;
    logic [15:0] cmd_data;
    logic        sdo_valid, sdo_ready;
    logic [31:0] sdo_data;
    logic        sync_valid = 1'b0;
    logic [7:0]  sync_id = 8'h0;
    logic        offload_done;

    trig_prog_seq u_trig_prog_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trigger(trigger),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
        .sync_valid(sync_valid), .sync_id(sync_id), .offload_done(offload_done)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    int cyc = 0;

    // reference model
    logic [15:0] m_cmd[$];
    logic [31:0] m_sdo[$];
    int m_state = 0;  // 0 idle, 1 run, 2 wait
    int m_cp = 0;
    int m_sp = 0;
    bit m_done = 0, m_en = 0, m_rst = 0, m_ovf = 0;
    bit n_done;

    logic [15:0] cap_cmd[$];
    logic [31:0] cap_sdo[$];
    int done_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // handshake patterns
    initial begin
        cmd_ready = 1'b0;
        sdo_ready = 1'b0;
    end
    always @(posedge clk) begin
        #1;
        cyc++;
        cmd_ready = (cyc % 3) != 1;
        sdo_ready = (cyc % 4) != 0;
        if (cyc > 50000 && !finished) begin
            chk(1'b0, "watchdog", "cycles", cyc, 50000);
            finish_up();
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd.delete(); m_sdo.delete();
            m_state = 0; m_cp = 0; m_sp = 0;
            m_done = 0; m_en = 0; m_rst = 0; m_ovf = 0;
        end else begin
            n_done = 0;
            if (m_rst) begin
                m_cmd.delete(); m_sdo.delete();
                m_state = 0; m_cp = 0; m_sp = 0; m_ovf = 0;
            end else begin
                if (m_state != 0 && m_sp < m_sdo.size() && sdo_ready) m_sp++;
                case (m_state)
                    0: if (m_en && trigger && m_cmd.size() > 0) begin
                           m_state = 1; m_cp = 0; m_sp = 0;
                       end
                    1: if (cmd_ready) begin
                           if (m_cp == m_cmd.size() - 1) m_state = 2;
                           else m_cp++;
                       end
                    2: if (sync_valid && sync_id == 8'h0) begin
                           m_state = 0; n_done = 1;
                       end
                    default: m_state = 0;
                endcase
                if (reg_wr && reg_addr == 3'd4) begin
                    if (m_cmd.size() < DEPTH) m_cmd.push_back(reg_wdata[15:0]);
                    else m_ovf = 1;
                end
                if (reg_wr && reg_addr == 3'd5) begin
                    if (m_sdo.size() < DEPTH) m_sdo.push_back(reg_wdata);
                    else m_ovf = 1;
                end
            end
            if (reg_wr && reg_addr == 3'd0) m_en = reg_wdata[0];
            if (reg_wr && reg_addr == 3'd1) m_rst = reg_wdata[0];
            m_done = n_done;
        end
    end

    function automatic logic [31:0] exp_rd();
        case (reg_addr)
            3'd0: return {31'h0, m_en};
            3'd1: return {31'h0, m_rst};
            3'd2: return {30'h0, m_ovf, m_state != 0};
            3'd3: return 32'h0000_0404;
            default: return 32'h0;
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(reg_rdata == exp_rd(), (reg_addr == 3'd3) ? "R10" : "R12",
                "reg_rdata", reg_rdata, exp_rd());
            chk(cmd_valid == (m_state == 1), "R3", "cmd_valid", cmd_valid, m_state == 1);
            if (cmd_valid && m_state == 1)
                chk(cmd_data == m_cmd[m_cp], "R3", "cmd_data", cmd_data, m_cmd[m_cp]);
            chk(sdo_valid == (m_state != 0 && m_sp < m_sdo.size()), "R4", "sdo_valid",
                sdo_valid, (m_state != 0 && m_sp < m_sdo.size()));
            if (sdo_valid && m_state != 0 && m_sp < m_sdo.size())
                chk(sdo_data == m_sdo[m_sp], "R4", "sdo_data", sdo_data, m_sdo[m_sp]);
            chk(offload_done == m_done, "R8", "offload_done", offload_done, m_done);
            if (cmd_valid && cmd_ready) cap_cmd.push_back(cmd_data);
            if (sdo_valid && sdo_ready) cap_sdo.push_back(sdo_data);
            if (offload_done) done_seen++;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1 trigger = 1'b1;
        @(posedge clk); #1 trigger = 1'b0;
    endtask

    task automatic send_sync(input logic [7:0] id);
        @(posedge clk); #1 sync_valid = 1'b1; sync_id = id;
        @(posedge clk); #1 sync_valid = 1'b0; sync_id = 8'h0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic wait_drained();
        while (m_state != 2) @(negedge clk);
    endtask

    logic [15:0] prog_a[5];
    logic [31:0] data_a[3];
    logic [31:0] rd;

    task automatic cmp_caps(input string tag);
        chk(cap_cmd.size() == 5, "R6", {tag, " cmd count"}, cap_cmd.size(), 5);
        for (int i = 0; i < 5 && i < cap_cmd.size(); i++)
            chk(cap_cmd[i] == prog_a[i], "R1", {tag, " cmd order"}, cap_cmd[i], prog_a[i]);
        chk(cap_sdo.size() == 3, "R4", {tag, " sdo count"}, cap_sdo.size(), 3);
        for (int i = 0; i < 3 && i < cap_sdo.size(); i++)
            chk(cap_sdo[i] == data_a[i], "R2", {tag, " sdo order"}, cap_sdo[i], data_a[i]);
    endtask

    initial begin
        prog_a = '{16'h2201, 16'h0110, 16'h1003, 16'h02ff, 16'h3000};
        data_a = '{32'hA5A5_0001, 32'h0000_BEEF, 32'h1234_5678};
        wait_cycles(3);
        #1 rst_n = 1'b1;

        reg_read(3'd3, rd);
        chk(rd == 32'h0404, "R10", "size word", rd, 32'h0404);
        reg_read(3'd2, rd);
        chk(rd == 32'h0, "R12", "status after reset", rd, 0);

        for (int i = 0; i < 5; i++) reg_write(3'd4, {16'h0, prog_a[i]});
        for (int i = 0; i < 3; i++) reg_write(3'd5, data_a[i]);

        // disabled trigger
        reg_addr = 3'd2;
        pulse_trig();
        wait_cycles(4);
        reg_read(3'd2, rd);
        chk(rd[0] == 1'b0, "R5", "busy while disabled", rd[0], 0);
        chk(cap_cmd.size() == 0, "R5", "no commands while disabled", cap_cmd.size(), 0);

        // first replay, with a trigger in the middle
        reg_write(3'd0, 32'h1);
        reg_read(3'd0, rd);
        chk(rd[0] == 1'b1, "R12", "enable readback", rd[0], 1);
        reg_addr = 3'd2;
        pulse_trig();
        reg_read(3'd2, rd);
        chk(rd[0] == 1'b1, "R12", "busy during replay", rd[0], 1);
        pulse_trig();
        wait_drained();
        send_sync(8'h05);
        wait_cycles(3);
        reg_read(3'd2, rd);
        chk(rd[0] == 1'b1, "R8", "busy after nonzero sync", rd[0], 1);
        chk(done_seen == 0, "R8", "no done on nonzero sync", done_seen, 0);
        send_sync(8'h00);
        wait_cycles(2);
        chk(done_seen == 1, "R8", "done pulses", done_seen, 1);
        reg_read(3'd2, rd);
        chk(rd[0] == 1'b0, "R8", "idle after sync", rd[0], 0);
        cmp_caps("run1");

        // second replay from unchanged memories
        cap_cmd.delete(); cap_sdo.delete();
        pulse_trig();
        wait_drained();
        send_sync(8'h00);
        wait_cycles(3);
        chk(done_seen == 2, "R7", "second done", done_seen, 2);
        cmp_caps("R7 run2");

        // clear register empties memories
        reg_write(3'd1, 32'h1);
        reg_read(3'd1, rd);
        chk(rd[0] == 1'b1, "R9", "clear readback", rd[0], 1);
        reg_write(3'd1, 32'h0);
        cap_cmd.delete(); cap_sdo.delete();
        reg_addr = 3'd2;
        pulse_trig();
        wait_cycles(3);
        reg_read(3'd2, rd);
        chk(rd[0] == 1'b0, "R13", "empty program not started", rd[0], 0);
        chk(cap_cmd.size() == 0, "R13", "no commands from empty memory", cap_cmd.size(), 0);

        // clear while replaying
        reg_write(3'd4, 32'h2201);
        reg_write(3'd4, 32'h0007);
        reg_write(3'd4, 32'h3000);
        reg_addr = 3'd2;
        pulse_trig();
        reg_write(3'd1, 32'h1);
        reg_read(3'd2, rd);
        chk(rd[0] == 1'b0, "R9", "replay abandoned", rd[0], 0);
        reg_write(3'd1, 32'h0);
        reg_addr = 3'd2;
        pulse_trig();
        wait_cycles(3);
        reg_read(3'd2, rd);
        chk(rd[0] == 1'b0, "R9", "memories empty after clear", rd[0], 0);

        // overflow
        for (int i = 0; i < DEPTH + 1; i++) reg_write(3'd4, 32'h5000 + i);
        reg_read(3'd2, rd);
        chk(rd[1] == 1'b1, "R11", "overflow flag", rd[1], 1);
        cap_cmd.delete(); cap_sdo.delete();
        pulse_trig();
        wait_drained();
        send_sync(8'h00);
        wait_cycles(3);
        chk(cap_cmd.size() == DEPTH, "R11", "replayed entries", cap_cmd.size(), DEPTH);
        if (cap_cmd.size() == DEPTH)
            chk(cap_cmd[DEPTH-1] == 16'h500F, "R11", "last kept entry",
                cap_cmd[DEPTH-1], 16'h500F);
        chk(cap_sdo.size() == 0, "R4", "no words from empty data memory", cap_sdo.size(), 0);
        reg_read(3'd2, rd);
        chk(rd[1] == 1'b1, "R11", "overflow stays set", rd[1], 1);
        reg_write(3'd1, 32'h1);
        reg_write(3'd1, 32'h0);
        reg_read(3'd2, rd);
        chk(rd[1] == 1'b0, "R9", "overflow cleared", rd[1], 0);

        wait_cycles(2);
        finish_up();
    end
endmodule